// File: doc/BRIEF.md
# Frame-Based Duplex Timing Generator

This block produces a set of frame-aligned control waveforms for systems that alternate between transmit and receive, or that need several signals switched in a fixed order. A 32-bit tick counter runs through one frame at a time. Each output channel is high during a window of that frame, set by its own start tick and stop tick. Each channel also has its own enable and polarity.

A burst starts on a sync event. The sync event comes from one of three places: a pin from outside, a periodic pulse made inside the block, or a trigger written by software. After the event the block waits a programmed number of ticks. It then runs a programmed number of frames and goes back to idle. A burst length of zero keeps the frames running until the global enable is cleared.

All configuration arrives as plain level inputs in the core clock domain. No pin uses a valid/ready handshake. The control and status pins are plain levels and pulses, so there is no back-pressure.

Top module: `tdd_timing_gen`

## Requirements
- R1: A channel's window holds ticks t with start <= t < stop when start < stop. It holds t >= start or t < stop when start > stop. It is empty when start equals stop.
- R2: A channel whose enable bit is 0 drives its polarity bit. An enabled channel drives polarity XOR (running AND tick in window), so polarity 1 inverts the waveform.
- R3: While running, the tick counter goes from 0 to frame_len-1 and then wraps to 0. A frame_len of 0 acts as 1. The frame_end output pulses for one cycle in the cycle that holds tick frame_len-1.
- R4: After a sync event is accepted in idle, the block is in the delay state for start_delay cycles, and then tick 0 of the first frame is output. With start_delay 0, tick 0 follows the event in the next cycle.
- R5: The block goes back to idle after the last tick of frame number burst_len. A burst_len of 0 repeats frames without limit.
- R6: sync_sel picks the sync source: 0 is the external pin, 1 is the internal periodic pulse, 2 is sw_trig (each high cycle is one event), and 3 is no source.
- R7: The external pin passes through two synchronizer flops and a rising-edge detector. With start_delay 0, a rise that is set up before clock edge n gives tick 0 after edge n+2. A pin that stays high gives no further events.
- R8: The internal source pulses once every sync_period cycles while enable is high. A period of 0 gives no pulses. Its counter is held at 0 while enable is low.
- R9: A sync event that arrives while the block is in the delay or run state is ignored. This includes the cycle that holds the last tick of a burst.
- R10: While enable is low, the block is idle, the tick counter is 0 and sync events are ignored. Clearing enable reaches idle on the next clock edge.
- R11: state_o encodes 0 as idle, 1 as delay and 2 as run. Outside the run state every channel drives its polarity bit.
- R12: After reset, the block is idle, frame_end is 0 and every channel drives its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable |
| sync_sel | input | 2 | Sync source select |
| ext_sync | input | 1 | External sync pin, asynchronous |
| sw_trig | input | 1 | Software trigger |
| sync_period | input | 32 | Internal sync period in cycles |
| start_delay | input | 32 | Startup delay in ticks |
| frame_len | input | 32 | Frame length in ticks |
| burst_len | input | 32 | Frames per burst, 0 = endless |
| ch_start | input | NCH*32 | Per-channel start tick, channel i at bits [32i+31:32i] |
| ch_stop | input | NCH*32 | Per-channel stop tick, same packing |
| ch_en | input | NCH | Per-channel enable |
| ch_pol | input | NCH | Per-channel polarity |
| ch_out | output | NCH | Channel waveforms |
| state_o | output | 2 | Idle, delay or run |
| frame_end | output | 1 | One-cycle pulse on the last tick of a frame |

## Verification
Two functions can fall in the same cycle. The first is the end of a burst's last frame, where the block leaves the run state. The second is a new sync event. The bench raises sw_trig exactly in the cycle that carries the last frame_end pulse. It then checks that the block drops to idle and that the total frame_end count stays at the burst length. It also raises a trigger in the same cycle that clears enable, and checks that the block stays idle.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } tdd_state_t;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_INT  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_NONE = 2'd3
  } tdd_src_t;
endpackage

// File: rtl/tdd_sync_src.sv
module tdd_sync_src #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    sel,
  input  logic          ext_sync,
  input  logic          sw_trig,
  input  logic [CW-1:0] period,
  output logic          sync_evt
);
  import tdd_pkg::*;

  logic          ext_s1, ext_s2, ext_d;
  logic          ext_rise;
  logic [CW-1:0] pcnt;
  logic          per_wrap;
  logic          int_pulse;

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_d  <= 1'b0;
    end else begin
      ext_s1 <= ext_sync;
      ext_s2 <= ext_s1;
      ext_d  <= ext_s2;
    end
  end

  assign ext_rise = ext_s2 & ~ext_d;

  // internal periodic source
  assign per_wrap  = ({1'b0, pcnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, period};
  assign int_pulse = enable && (period != '0) && per_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || period == '0) pcnt <= '0;
    else if (per_wrap)                      pcnt <= '0;
    else                                    pcnt <= pcnt + 1'b1;
  end

  always_comb begin
    unique case (tdd_src_t'(sel))
      SRC_EXT:  sync_evt = ext_rise;
      SRC_INT:  sync_evt = int_pulse;
      SRC_SW:   sync_evt = sw_trig;
      default:  sync_evt = 1'b0;
    endcase
  end

  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  a_r8_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pulse && period > 1 && $stable(period)) |=> !int_pulse);
endmodule

// File: rtl/tdd_frame_ctrl.sv
module tdd_frame_ctrl #(
  parameter int CW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           sync_evt,
  input  logic [CW-1:0]  delay,
  input  logic [CW-1:0]  len,
  input  logic [CW-1:0]  burst,
  output tdd_pkg::tdd_state_t state,
  output logic [CW-1:0]  tick,
  output logic           frame_end
);
  import tdd_pkg::*;

  logic [CW-1:0] fcnt;
  logic [CW:0]   tick_nxt;
  logic          delay_done;
  logic          frame_last;
  logic          burst_last;

  assign tick_nxt   = {1'b0, tick} + {{CW{1'b0}}, 1'b1};
  assign delay_done = tick_nxt >= {1'b0, delay};
  assign frame_last = tick_nxt >= {1'b0, len};
  assign burst_last = (burst != '0) &&
                      (({1'b0, fcnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, burst});
  assign frame_end  = (state == ST_RUN) && frame_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= ST_IDLE;
      tick  <= '0;
      fcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tick <= '0;
          fcnt <= '0;
          if (sync_evt) state <= (delay == '0) ? ST_RUN : ST_DELAY;
        end
        ST_DELAY: begin
          if (delay_done) begin
            tick  <= '0;
            state <= ST_RUN;
          end else begin
            tick <= tick_nxt[CW-1:0];
          end
        end
        ST_RUN: begin
          if (frame_last) begin
            tick <= '0;
            if (burst_last) state <= ST_IDLE;
            else            fcnt  <= fcnt + 1'b1;
          end else begin
            tick <= tick_nxt[CW-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE && tick == '0));

  a_r4_delay_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY && $past(state) != ST_DELAY) |-> $past(state) == ST_IDLE);

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && enable) |=> (tick == '0));

  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && enable && !frame_last) |=> state == ST_RUN);
endmodule

// File: rtl/tdd_channel.sv
module tdd_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] tick,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] stop,
  input  logic          en,
  input  logic          pol,
  output logic          out
);
  logic in_win;

  always_comb begin
    if (start < stop)      in_win = (tick >= start) && (tick < stop);
    else if (start > stop) in_win = (tick >= start) || (tick < stop);
    else                   in_win = 1'b0;
  end

  assign out = pol ^ (run & en & in_win);

  a_r1_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (start == stop) |-> (out == pol));
endmodule

// File: rtl/tdd_timing_gen.sv
module tdd_timing_gen #(
  parameter int NCH = 8,
  parameter int CW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       sync_sel,
  input  logic             ext_sync,
  input  logic             sw_trig,
  input  logic [CW-1:0]    sync_period,
  input  logic [CW-1:0]    start_delay,
  input  logic [CW-1:0]    frame_len,
  input  logic [CW-1:0]    burst_len,
  input  logic [NCH*CW-1:0] ch_start,
  input  logic [NCH*CW-1:0] ch_stop,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH-1:0]   ch_pol,
  output logic [NCH-1:0]   ch_out,
  output logic [1:0]       state_o,
  output logic             frame_end
);
  import tdd_pkg::*;

  logic          sync_evt;
  tdd_state_t    state;
  logic [CW-1:0] tick;
  logic          run;

  tdd_sync_src #(.CW(CW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .sel      (sync_sel),
    .ext_sync (ext_sync),
    .sw_trig  (sw_trig),
    .period   (sync_period),
    .sync_evt (sync_evt)
  );

  tdd_frame_ctrl #(.CW(CW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sync_evt  (sync_evt),
    .delay     (start_delay),
    .len       (frame_len),
    .burst     (burst_len),
    .state     (state),
    .tick      (tick),
    .frame_end (frame_end)
  );

  assign run     = (state == ST_RUN);
  assign state_o = state;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    tdd_channel #(.CW(CW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .start (ch_start[gi*CW +: CW]),
      .stop  (ch_stop[gi*CW +: CW]),
      .en    (ch_en[gi]),
      .pol   (ch_pol[gi]),
      .out   (ch_out[gi])
    );
  end

  a_r11_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2) |-> (ch_out == ch_pol));

  a_r3_end_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (state_o == 2'd2));
endmodule

// File: tb/test_tdd_timing_gen.sv
`timescale 1ns/1ps
module test_tdd_timing_gen;
  localparam int NCH = 8;
  localparam int CW  = 32;

  typedef struct packed {
    logic [7:0] start;
    logic [7:0] stop;
    logic       pol;
    logic       en;
    logic [7:0] pat;   // bit t = expected ch_out[0] at tick t
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{8'd2, 8'd5, 1'b0, 1'b1, 8'h1C},
    '{8'd2, 8'd5, 1'b1, 1'b1, 8'hE3},
    '{8'd3, 8'd3, 1'b0, 1'b1, 8'h00},
    '{8'd6, 8'd2, 1'b0, 1'b1, 8'hC3},
    '{8'd1, 8'd4, 1'b1, 1'b0, 8'hFF},
    '{8'd0, 8'd8, 1'b0, 1'b1, 8'hFF},
    '{8'd7, 8'd0, 1'b0, 1'b1, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] sync_sel = 2'd2;
  logic ext_sync = 1'b0;
  logic sw_trig = 1'b0;
  logic [CW-1:0] sync_period = '0;
  logic [CW-1:0] start_delay = '0;
  logic [CW-1:0] frame_len = 32'd8;
  logic [CW-1:0] burst_len = 32'd1;
  logic [NCH*CW-1:0] ch_start = '0;
  logic [NCH*CW-1:0] ch_stop = '0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH-1:0] ch_pol = '0;
  logic [NCH-1:0] ch_out;
  logic [1:0] state_o;
  logic frame_end;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdd_timing_gen #(.NCH(NCH), .CW(CW)) i_tdd_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_sel(sync_sel),
    .ext_sync(ext_sync), .sw_trig(sw_trig), .sync_period(sync_period),
    .start_delay(start_delay), .frame_len(frame_len), .burst_len(burst_len),
    .ch_start(ch_start), .ch_stop(ch_stop), .ch_en(ch_en), .ch_pol(ch_pol),
    .ch_out(ch_out), .state_o(state_o), .frame_end(frame_end)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire_sw();
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
  endtask

  task automatic set_ch0(input logic [7:0] s, input logic [7:0] e, input logic p, input logic en);
    ch_start[CW-1:0] = {24'd0, s};
    ch_stop[CW-1:0]  = {24'd0, e};
    ch_pol[0] = p;
    ch_en[0]  = en;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int k1, k2, fe;
    logic [1:0] prev;
    // R12: reset state
    ch_pol = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 state", state_o, 0);
    chk("R12 frame_end", frame_end, 0);
    chk("R12 outputs", ch_out, 8'hA5);
    ch_pol = '0;
    enable = 1'b1;
    @(negedge clk);

    // R1 R2 R3: table walk, frame_len 8, one frame per burst
    foreach (TBL[v]) begin
      set_ch0(TBL[v].start, TBL[v].stop, TBL[v].pol, TBL[v].en);
      fire_sw();
      for (int t = 0; t < 8; t++) begin
        chk($sformatf("R1/R2 vec%0d tick%0d", v, t), ch_out[0], TBL[v].pat[t]);
        if (t == 7) chk("R3 frame_end on last tick", frame_end, 1);
        @(negedge clk);
      end
      chk("R5 idle after one frame", state_o, 0);
    end

    // R4: startup delay of 3
    start_delay = 32'd3; frame_len = 32'd4; burst_len = 32'd1;
    set_ch0(8'd0, 8'd1, 1'b0, 1'b1);
    fire_sw();
    chk("R4 delay k0", state_o, 1);
    @(negedge clk); @(negedge clk);
    chk("R4 delay k2", state_o, 1);
    @(negedge clk);
    chk("R4 run at k3", state_o, 2);
    chk("R4 tick0 output", ch_out[0], 1);
    repeat (6) @(negedge clk);
    start_delay = '0;

    // R5 R9: burst of 3, retrigger on the last frame_end cycle
    burst_len = 32'd3; fe = 0;
    fire_sw();
    for (int k = 0; k < 20; k++) begin
      if (frame_end) fe++;
      if (k == 12) chk("R9 idle after retrigger on last frame", state_o, 0);
      if (k == 11) begin
        chk("R3 last frame_end k11", frame_end, 1);
        sw_trig = 1'b1;
      end else sw_trig = 1'b0;
      @(negedge clk);
    end
    chk("R5 frame count burst3", fe, 3);
    chk("R9 still idle", state_o, 0);

    // R5 R10: endless burst then disable
    burst_len = '0; fe = 0;
    set_ch0(8'd0, 8'd2, 1'b1, 1'b1);
    fire_sw();
    for (int k = 0; k < 30; k++) begin
      if (frame_end) fe++;
      @(negedge clk);
    end
    chk("R5 endless frame count", fe, 7);
    chk("R5 still running", state_o, 2);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 idle after disable", state_o, 0);
    chk("R10 outputs inactive", ch_out, 8'h01);
    // R10: trigger together with disable is ignored
    sw_trig = 1'b1;
    @(negedge clk);
    chk("R10 trigger while disabled", state_o, 0);
    sw_trig = 1'b0; enable = 1'b1;
    @(negedge clk);
    chk("R10 no late start", state_o, 0);

    // R6 R7: external source, three-cycle latency
    burst_len = 32'd1; sync_sel = 2'd0;
    @(negedge clk) ext_sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 idle at n2", state_o, 0);
    @(negedge clk);
    chk("R7 run at n3", state_o, 2);
    repeat (8) @(negedge clk);
    chk("R7 held pin no retrigger", state_o, 0);
    ext_sync = 1'b0;

    // R6 R8: internal periodic source, period 10
    sync_period = 32'd10; sync_sel = 2'd1;
    k1 = -1; k2 = -1; prev = state_o;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (prev != 2'd2 && state_o == 2'd2) begin
        if (k1 < 0) k1 = k; else if (k2 < 0) k2 = k;
      end
      prev = state_o;
    end
    chk("R8 internal sync seen", (k1 >= 0 && k2 >= 0), 1);
    chk("R8 start interval", k2 - k1, 10);

    // R6: select 3 gives no source
    sync_sel = 2'd3;
    repeat (3) @(negedge clk);
    sw_trig = 1'b1;
    repeat (25) @(negedge clk);
    sw_trig = 1'b0;
    chk("R6 no source stays idle", state_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule